// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for one display. A horizontal counter runs from 0 up to a programmed total and then wraps. Each wrap of the horizontal counter advances a vertical counter, which wraps at its own programmed total. Software places every region of a line and of a frame by writing its start position: picture, right border, blanking, sync, back porch and left border (top border on the vertical axis). The counter values are decoded into sync pins with programmable polarity, a data-enable pin, a border flag with a programmable border colour, and three sticky interrupts: line, vertical blank and error.

All settings go through a small word-addressed register port. The timing values apply through shadow copies, so that a reprogrammed raster takes effect cleanly at a frame edge. A swap register holds a next-buffer select. That select is copied into the displayed-buffer flag when a new frame starts. The same register acknowledges interrupts. Both counters can be read back.

Top module: `disp_timing_ctrl`

## Requirements
- R1: After reset both counters read 0, every register reads 0, de_o, border_o, disp_buf_o and all irq outputs are low, and hsync_o and vsync_o are high (active-low sync, inactive).
- R2: While control bit 0 (run) is set, the horizontal count steps by one each cycle and goes from its total back to 0. The vertical count steps on each horizontal wrap and goes from its total back to 0. While run is clear, both counts are held at 0. Register 18 returns the horizontal count and register 19 the vertical count.
- R3: Timing register values apply only through shadow copies. The shadows load on the edge after the last pixel of a frame (both counts at their totals), and on any edge while run is clear. A timing register read returns the written value at once. A range register holds the start in bits 15:0 and the end in bits 31:16.
- R4: H-sync is active for h in [sync start, back porch start). V-sync is active for v in the same range of the vertical registers. Register 16 bit 0 set makes H-sync active high and bit 4 set makes V-sync active high. When run or control bit 16 (output enable) is clear, both pins sit at their inactive level.
- R5: de_o is high when output is active, h is in [picture start, border start) and v is in the corresponding vertical range.
- R6: An axis is visible when its count is below its blank start or at or above its left/top border start. border_o is high when output is active, both axes are visible and de_o would be low. border_rgb_o always equals register 17, which holds red in 7:0, green in 15:8 and blue in 23:16.
- R7: Writing register 21 sets the next-buffer select from bit 0. disp_buf_o, also read back as bit 4 of register 21, copies the select only on a frame-start edge.
- R8: The line interrupt sets when run is set, h equals the horizontal range start, and both h and v lie inside their inclusive start..end ranges.
- R9: The vertical-blank interrupt sets when run is set, v equals the vertical blank start and h is 0.
- R10: The error interrupt sets on a cycle with fifo_err_i high while run is set.
- R11: Control bits 8, 9 and 10 stop the line, vertical-blank and error interrupts from setting. Writing 1 to register 21 bits 16, 17 or 18 clears the matching flag, and a new event in the same cycle wins over the clear. The flags read back in register 21 bits 18:16.
- R12: Register map: 0..7 horizontal total, picture, border, blank, sync, back porch, left border, range; 8..15 the vertical set in the same order with top border; 16 polarity; 17 colour; 20 control; counters and swap as above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| fifo_err_i | input | 1 | Error event from the pixel supply |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Picture data enable |
| border_o | output | 1 | Border region flag |
| border_rgb_o | output | 24 | Border colour |
| disp_buf_o | output | 1 | Buffer currently displayed |
| irq_line_o | output | 1 | Line interrupt flag |
| irq_vblank_o | output | 1 | Vertical-blank interrupt flag |
| irq_err_o | output | 1 | Error interrupt flag |

## Verification
The bench builds the block with a 10-bit counter width and programs random rasters of roughly twenty pixels by twenty lines. Each frame is then only a few hundred cycles, so one run covers dozens of frame edges, shadow reloads, buffer swaps and interrupt windows. Across the rounds the timing registers are rewritten while the raster runs, the polarities and masks vary, and the output enable is turned off.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  // Field index inside one axis configuration
  localparam int TF_TOT  = 0;
  localparam int TF_PIC  = 1;
  localparam int TF_BRD  = 2;
  localparam int TF_BLK  = 3;
  localparam int TF_SYN  = 4;
  localparam int TF_BP   = 5;
  localparam int TF_LB   = 6;
  localparam int TF_IRQS = 7;
  localparam int TF_IRQE = 8;
  localparam int NTF     = 9;

  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] RA_POL   = 5'd16;
  localparam logic [ADDR_W-1:0] RA_COLOR = 5'd17;
  localparam logic [ADDR_W-1:0] RA_HCNT  = 5'd18;
  localparam logic [ADDR_W-1:0] RA_VCNT  = 5'd19;
  localparam logic [ADDR_W-1:0] RA_CTRL  = 5'd20;
  localparam logic [ADDR_W-1:0] RA_SWAP  = 5'd21;
endpackage

// File: rtl/dtc_axis.sv
module dtc_axis
  import dtc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int MARK_SEL = TF_IRQS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       step,
  input  logic                       load,
  input  logic [NTF-1:0][CNT_W-1:0]  cfg_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic                       term_o,
  output logic                       pic_o,
  output logic                       vis_o,
  output logic                       sync_o,
  output logic                       mark_o,
  output logic                       win_o
);
  logic [NTF-1:0][CNT_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]          cnt_q, cnt_d;

  always_comb begin
    sh_d   = load ? cfg_i : sh_q;
    term_o = (cnt_q == sh_q[TF_TOT]);
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = term_o ? '0 : cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // Region decode from the running count and the active shadow set
  assign cnt_o  = cnt_q;
  assign pic_o  = (cnt_q >= sh_q[TF_PIC]) && (cnt_q < sh_q[TF_BRD]);
  assign vis_o  = (cnt_q < sh_q[TF_BLK]) || (cnt_q >= sh_q[TF_LB]);
  assign sync_o = (cnt_q >= sh_q[TF_SYN]) && (cnt_q < sh_q[TF_BP]);
  assign mark_o = (cnt_q == sh_q[MARK_SEL]);
  assign win_o  = (cnt_q >= sh_q[TF_IRQS]) && (cnt_q <= sh_q[TF_IRQE]);
endmodule

// File: rtl/dtc_regs.sv
module dtc_regs
  import dtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [31:0]                wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [31:0]                rd_data,
  input  logic [CNT_W-1:0]           hcnt,
  input  logic [CNT_W-1:0]           vcnt,
  input  logic                       frame_start,
  input  logic                       ev_line,
  input  logic                       ev_vblank,
  input  logic                       ev_err,
  output logic [NTF-1:0][CNT_W-1:0]  hcfg,
  output logic [NTF-1:0][CNT_W-1:0]  vcfg,
  output logic                       hpol,
  output logic                       vpol,
  output logic [23:0]                color,
  output logic                       run,
  output logic                       out_en,
  output logic                       cur_buf,
  output logic [2:0]                 irq
);
  logic [NTF-1:0][CNT_W-1:0] hcfg_q, hcfg_d, vcfg_q, vcfg_d, rsel;
  logic        hpol_q, hpol_d, vpol_q, vpol_d;
  logic [23:0] col_q, col_d;
  logic        run_q, run_d, oen_q, oen_d;
  logic [2:0]  msk_q, msk_d, irq_q, irq_d, ack;
  logic        nxt_q, nxt_d, cur_q, cur_d;
  logic [3:0]  fidx, ridx;

  function automatic logic [15:0] ext16(input logic [CNT_W-1:0] x);
    ext16 = '0;
    ext16[CNT_W-1:0] = x;
  endfunction

  // Next-state logic
  always_comb begin
    hcfg_d = hcfg_q;  vcfg_d = vcfg_q;
    hpol_d = hpol_q;  vpol_d = vpol_q;
    col_d  = col_q;
    run_d  = run_q;   oen_d  = oen_q;  msk_d = msk_q;
    nxt_d  = nxt_q;
    ack    = '0;
    fidx   = {1'b0, wr_addr[2:0]};
    if (wr_en) begin
      if (!wr_addr[ADDR_W-1]) begin
        if (wr_addr[3]) begin
          if (fidx == 4'd7) begin
            vcfg_d[TF_IRQS] = wr_data[CNT_W-1:0];
            vcfg_d[TF_IRQE] = wr_data[16 +: CNT_W];
          end else begin
            vcfg_d[fidx] = wr_data[CNT_W-1:0];
          end
        end else begin
          if (fidx == 4'd7) begin
            hcfg_d[TF_IRQS] = wr_data[CNT_W-1:0];
            hcfg_d[TF_IRQE] = wr_data[16 +: CNT_W];
          end else begin
            hcfg_d[fidx] = wr_data[CNT_W-1:0];
          end
        end
      end else begin
        case (wr_addr)
          RA_POL:   begin hpol_d = wr_data[0]; vpol_d = wr_data[4]; end
          RA_COLOR: col_d = wr_data[23:0];
          RA_CTRL:  begin run_d = wr_data[0]; msk_d = wr_data[10:8]; oen_d = wr_data[16]; end
          RA_SWAP:  begin nxt_d = wr_data[0]; ack = wr_data[18:16]; end
          default:  ;
        endcase
      end
    end
    cur_d = frame_start ? nxt_q : cur_q;
    irq_d = (irq_q & ~ack) | ({ev_err, ev_vblank, ev_line} & ~msk_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcfg_q <= '0;  vcfg_q <= '0;
      hpol_q <= 1'b0; vpol_q <= 1'b0;
      col_q  <= '0;
      run_q  <= 1'b0; oen_q <= 1'b0; msk_q <= '0;
      nxt_q  <= 1'b0; cur_q <= 1'b0;
      irq_q  <= '0;
    end else begin
      hcfg_q <= hcfg_d;  vcfg_q <= vcfg_d;
      hpol_q <= hpol_d;  vpol_q <= vpol_d;
      col_q  <= col_d;
      run_q  <= run_d;   oen_q <= oen_d;  msk_q <= msk_d;
      nxt_q  <= nxt_d;   cur_q <= cur_d;
      irq_q  <= irq_d;
    end
  end

  // Read mux
  always_comb begin
    rsel    = rd_addr[3] ? vcfg_q : hcfg_q;
    ridx    = {1'b0, rd_addr[2:0]};
    rd_data = '0;
    if (!rd_addr[ADDR_W-1]) begin
      if (ridx == 4'd7) rd_data = {ext16(rsel[TF_IRQE]), ext16(rsel[TF_IRQS])};
      else              rd_data = {16'h0, ext16(rsel[ridx])};
    end else begin
      case (rd_addr)
        RA_POL:   rd_data = {27'h0, vpol_q, 3'h0, hpol_q};
        RA_COLOR: rd_data = {8'h0, col_q};
        RA_HCNT:  rd_data = {16'h0, ext16(hcnt)};
        RA_VCNT:  rd_data = {16'h0, ext16(vcnt)};
        RA_CTRL:  rd_data = {15'h0, oen_q, 5'h0, msk_q, 7'h0, run_q};
        RA_SWAP:  rd_data = {13'h0, irq_q, 11'h0, cur_q, 3'h0, nxt_q};
        default:  rd_data = '0;
      endcase
    end
  end

  assign hcfg    = hcfg_q;
  assign vcfg    = vcfg_q;
  assign hpol    = hpol_q;
  assign vpol    = vpol_q;
  assign color   = col_q;
  assign run     = run_q;
  assign out_en  = oen_q;
  assign cur_buf = cur_q;
  assign irq     = irq_q;
endmodule

// File: rtl/disp_timing_ctrl.sv
module disp_timing_ctrl
  import dtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [4:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              fifo_err_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              border_o,
  output logic [23:0]       border_rgb_o,
  output logic              disp_buf_o,
  output logic              irq_line_o,
  output logic              irq_vblank_o,
  output logic              irq_err_o
);
  logic [NTF-1:0][CNT_W-1:0] hcfg, vcfg;
  logic [NTF-1:0][CNT_W-1:0] cfg [2];
  logic [CNT_W-1:0]          cnt [2];
  logic term [2], pic [2], vis [2], syn [2], mark [2], win [2];
  logic [CNT_W-1:0] hcnt, vcnt;
  logic hpol, vpol, run, out_en, cur_buf, active, load, frame_end, hterm;
  logic ev_line, ev_vblank, ev_err, both_pic;
  logic [2:0]  irq;
  logic [23:0] color;

  assign cfg[0] = hcfg;
  assign cfg[1] = vcfg;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    dtc_axis #(
      .CNT_W    (CNT_W),
      .MARK_SEL (a == 0 ? TF_IRQS : TF_BLK)
    ) u_axis (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (~run),
      .step   (a == 0 ? run : (run & hterm)),
      .load   (load),
      .cfg_i  (cfg[a]),
      .cnt_o  (cnt[a]),
      .term_o (term[a]),
      .pic_o  (pic[a]),
      .vis_o  (vis[a]),
      .sync_o (syn[a]),
      .mark_o (mark[a]),
      .win_o  (win[a])
    );
  end

  assign hcnt      = cnt[0];
  assign vcnt      = cnt[1];
  assign hterm     = term[0];
  assign frame_end = run & term[0] & term[1];
  assign load      = ~run | frame_end;
  assign ev_line   = run & mark[0] & win[0] & win[1];
  assign ev_vblank = run & mark[1] & (hcnt == '0);
  assign ev_err    = run & fifo_err_i;

  dtc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .hcnt        (hcnt),
    .vcnt        (vcnt),
    .frame_start (frame_end),
    .ev_line     (ev_line),
    .ev_vblank   (ev_vblank),
    .ev_err      (ev_err),
    .hcfg        (hcfg),
    .vcfg        (vcfg),
    .hpol        (hpol),
    .vpol        (vpol),
    .color       (color),
    .run         (run),
    .out_en      (out_en),
    .cur_buf     (cur_buf),
    .irq         (irq)
  );

  // Pin decode
  assign active       = run & out_en;
  assign both_pic     = pic[0] & pic[1];
  assign de_o         = active & both_pic;
  assign border_o     = active & vis[0] & vis[1] & ~both_pic;
  assign hsync_o      = hpol ? (active & syn[0]) : ~(active & syn[0]);
  assign vsync_o      = vpol ? (active & syn[1]) : ~(active & syn[1]);
  assign border_rgb_o = color;
  assign disp_buf_o   = cur_buf;
  assign irq_line_o   = irq[0];
  assign irq_vblank_o = irq[1];
  assign irq_err_o    = irq[2];
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             active,
  input logic             frame_end,
  input logic             hterm,
  input logic [CNT_W-1:0] hcnt,
  input logic [CNT_W-1:0] vcnt,
  input logic             ack_vblank,
  input logic             ev_vblank,
  input logic             de_o,
  input logic             border_o,
  input logic             disp_buf_o,
  input logic             irq_vblank_o
);
  AST_STOP_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hcnt == '0) && (vcnt == '0)); // R2

  AST_HCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !hterm) |=> (hcnt == $past(hcnt) + 1'b1)); // R2

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!de_o && !border_o)); // R5

  AST_DE_BORDER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(de_o && border_o)); // R6

  AST_BUF_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_buf_o) |-> $past(frame_end)); // R7

  AST_VBLANK_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vblank && !ev_vblank) |=> !irq_vblank_o); // R11
endmodule

bind disp_timing_ctrl dtc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run          (run),
  .active       (active),
  .frame_end    (frame_end),
  .hterm        (hterm),
  .hcnt         (hcnt),
  .vcnt         (vcnt),
  .ack_vblank   (wr_en && (wr_addr == 5'd21) && wr_data[17]),
  .ev_vblank    (ev_vblank),
  .de_o         (de_o),
  .border_o     (border_o),
  .disp_buf_o   (disp_buf_o),
  .irq_vblank_o (irq_vblank_o)
);

// File: tb/disp_timing_ctrl_tb.sv
module disp_timing_ctrl_tb;
  localparam int CW = 10;

  logic        clk, rst_n, wr_en, fifo_err_i;
  logic [4:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        hsync_o, vsync_o, de_o, border_o, disp_buf_o;
  logic        irq_line_o, irq_vblank_o, irq_err_o;
  logic [23:0] border_rgb_o;

  disp_timing_ctrl #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fifo_err_i(fifo_err_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .border_o(border_o),
    .border_rgb_o(border_rgb_o), .disp_buf_o(disp_buf_o), .irq_line_o(irq_line_o),
    .irq_vblank_o(irq_vblank_o), .irq_err_o(irq_err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference state derived from the requirements
  int        n_chk, n_fail;
  int        mh, mv;
  int        prog [2][9];
  int        sh   [2][9];
  bit        m_run, m_out, m_hpol, m_vpol, m_next, m_cur;
  bit [2:0]  m_irq, m_msk;
  bit [23:0] m_col;
  int        rd_sel;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit inrng(input int a, input int c, input int lo, input int hi);
    return (c >= sh[a][lo]) && (c < sh[a][hi]);
  endfunction

  function automatic bit inwin(input int a, input int c);
    return (c >= sh[a][7]) && (c <= sh[a][8]);
  endfunction

  // Advance the reference across one rising edge
  task automatic model_edge(input bit we, input int addr, input bit [31:0] d, input bit err);
    bit fe, hw, evl, evv, eve;
    bit [2:0] ack;
    fe  = m_run && mh == sh[0][0] && mv == sh[1][0];
    evl = m_run && mh == sh[0][7] && inwin(0, mh) && inwin(1, mv);
    evv = m_run && mv == sh[1][3] && mh == 0;
    eve = m_run && err;
    ack = (we && addr == 21) ? d[18:16] : 3'b000;
    m_irq = (m_irq & ~ack) | ({eve, evv, evl} & ~m_msk);
    if (!m_run) begin
      mh = 0; mv = 0;
    end else begin
      hw = (mh == sh[0][0]);
      mh = hw ? 0 : mh + 1;
      if (hw) mv = (mv == sh[1][0]) ? 0 : mv + 1;
    end
    if (fe) m_cur = m_next;
    if (!m_run || fe) sh = prog;
    if (we) begin
      if (addr < 16) begin
        if (addr % 8 == 7) begin
          prog[addr/8][7] = int'(d[CW-1:0]);
          prog[addr/8][8] = int'(d[16 +: CW]);
        end else begin
          prog[addr/8][addr%8] = int'(d[CW-1:0]);
        end
      end else if (addr == 16) begin m_hpol = d[0]; m_vpol = d[4]; end
      else if (addr == 17) m_col = d[23:0];
      else if (addr == 20) begin m_run = d[0]; m_msk = d[10:8]; m_out = d[16]; end
      else if (addr == 21) m_next = d[0];
    end
  endtask

  task automatic check_all();
    bit act, hs, vs, pic, brd;
    int exp_rd;
    act = m_run && m_out;
    hs  = act && inrng(0, mh, 4, 5);
    vs  = act && inrng(1, mv, 4, 5);
    pic = inrng(0, mh, 1, 2) && inrng(1, mv, 1, 2);
    brd = act && (mh < sh[0][3] || mh >= sh[0][6]) && (mv < sh[1][3] || mv >= sh[1][6]) && !pic;
    chk("R4 hsync", int'(hsync_o), int'(m_hpol ? hs : !hs));
    chk("R4 vsync", int'(vsync_o), int'(m_vpol ? vs : !vs));
    chk("R5 de", int'(de_o), int'(act && pic));
    chk("R6 border", int'(border_o), int'(brd));
    chk("R6 colour", int'(border_rgb_o), int'(m_col));
    chk("R7 disp_buf", int'(disp_buf_o), int'(m_cur));
    chk("R8 irq_line", int'(irq_line_o), int'(m_irq[0]));
    chk("R9 irq_vblank", int'(irq_vblank_o), int'(m_irq[1]));
    chk("R10 irq_err", int'(irq_err_o), int'(m_irq[2]));
    rd_sel = (rd_sel + 1) % 3;
    rd_addr = 5'(18 + rd_sel + (rd_sel == 2 ? 1 : 0));
    #1;
    if (rd_sel == 0)      chk("R2/R3 hcount readback", int'(rd_data), mh);
    else if (rd_sel == 1) chk("R2/R3 vcount readback", int'(rd_data), mv);
    else begin
      exp_rd = (int'(m_irq) << 16) | (int'(m_cur) << 4) | int'(m_next);
      chk("R11/R12 swap readback", int'(rd_data), exp_rd);
    end
  endtask

  task automatic tick(input bit we, input int addr, input bit [31:0] d, input bit err);
    wr_en = we; wr_addr = 5'(addr); wr_data = d; fifo_err_i = err;
    @(posedge clk);
    model_edge(we, addr, d, err);
    @(negedge clk);
    wr_en = 1'b0; fifo_err_i = 1'b0;
    check_all();
  endtask

  task automatic wr(input int addr, input bit [31:0] d);
    tick(1'b1, addr, d, 1'b0);
  endtask

  task automatic rand_cfg(input int a);
    int p [7];
    int c, s, e;
    c = int'($urandom % 3);
    p[1] = c;
    for (int k = 2; k < 7; k++) begin
      c += 1 + int'($urandom % 4);
      p[k] = c;
    end
    p[0] = c + 1 + int'($urandom % 4);
    s = int'($urandom % (p[0] + 1));
    e = s + int'($urandom % 4);
    for (int k = 0; k < 7; k++) wr(a*8 + k, 32'(p[k]));
    wr(a*8 + 7, (32'(e) << 16) | 32'(s));
    rd_addr = 5'(a*8 + 7);
    #1;
    chk("R3/R12 range readback", int'(rd_data), (e << 16) | s);
    rd_addr = 5'(a*8 + 3);
    #1;
    chk("R3/R12 blank readback", int'(rd_data), p[3]);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; rd_sel = 0;
    mh = 0; mv = 0; m_run = 0; m_out = 0; m_hpol = 0; m_vpol = 0;
    m_next = 0; m_cur = 0; m_irq = '0; m_msk = '0; m_col = '0;
    for (int a = 0; a < 2; a++)
      for (int k = 0; k < 9; k++) begin prog[a][k] = 0; sh[a][k] = 0; end
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; fifo_err_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 hsync idle", int'(hsync_o), 1);
    chk("R1 vsync idle", int'(vsync_o), 1);
    chk("R1 de", int'(de_o), 0);
    chk("R1 irq", int'({irq_err_o, irq_vblank_o, irq_line_o}), 0);
    rd_addr = 5'd20; #1;
    chk("R1 control reg", int'(rd_data), 0);
    rd_addr = 5'd18; #1;
    chk("R1 hcount", int'(rd_data), 0);
    check_all();

    for (int r = 0; r < 6; r++) begin
      // Rounds after the first rewrite timing while running (R3 shadow)
      rand_cfg(0);
      rand_cfg(1);
      wr(16, {27'h0, 1'($urandom), 3'h0, 1'($urandom)});
      wr(17, 32'($urandom) & 32'h00FF_FFFF);
      wr(20, {15'h0, (r != 2), 5'h0, (r == 3) ? 3'($urandom) : 3'b000, 7'h0, 1'b1});
      for (int i = 0; i < 900; i++) begin
        if ($urandom % 90 == 0)
          tick(1'b1, 21, {13'h0, 3'($urandom), 15'h0, 1'($urandom)}, 1'($urandom % 40 == 0));
        else
          tick(1'b0, 0, 32'h0, 1'($urandom % 40 == 0));
      end
      if (r == 4) begin
        // R2: stopping holds both counts at 0
        wr(20, 32'h0);
        repeat (20) tick(1'b0, 0, 32'h0, 1'b1);
        chk("R2 stopped hcount", int'(mh), 0);
      end
    end
    // R11: acknowledge all pending flags while stopped
    wr(20, 32'h0);
    wr(21, 32'h0007_0000);
    chk("R11 ack clears", int'({irq_err_o, irq_vblank_o, irq_line_o}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule